// File: doc/BRIEF.md
# USB Device Endpoint Handshake Responder

This block is the device-side handshake engine for a high-speed capable USB function. It serves a control endpoint in slot 0 and five general endpoint slots. Each general slot has its own endpoint number, direction, maximum packet size and buffer capacity. The block keeps a byte-occupancy count for each slot's buffer region. The host-facing packet engine hands the block already-decoded token events, each carrying a kind (IN, OUT or PING), an endpoint number and, for OUT, the payload length. The block picks the slot that the token addresses and compares that slot's occupancy, or its free space, with the maximum packet size. It then answers in hardware with DATA, ACK, NAK or NYET, so firmware never takes part in a single transaction.

The local processor moves data through a write-credit port and a read-credit port. The write port adds bytes to an IN buffer and the read port drains bytes from an OUT buffer. The host's acknowledgement of a DATA reply removes the bytes that were sent. A per-slot "short send" control lets an IN endpoint release less than one full packet, including an empty one. High-speed flow control (PING answers and NYET) applies only when the link has negotiated high speed and the force-full-speed control is low.

Top module: `ep_handshake_resp`

## Requirements
- R1: After reset every buffer count is zero and `rsp_valid` is low until a token arrives.
- R2: An IN token to an IN slot holding at least one maximum packet gets DATA (`rsp_code`=0) with `rsp_len` equal to the maximum packet size. A later `host_ack` pulse removes those bytes from the buffer.
- R3: If no `host_ack` arrives before the next token, the bytes of a DATA reply stay in the buffer and are offered again.
- R4: An IN token to a slot holding less than one maximum packet gets NAK (`rsp_code`=2) when that slot's short-send bit is low. When the bit is high it gets DATA with `rsp_len` equal to the bytes held, and zero is allowed.
- R5: At high speed a PING (`tok_kind`=2) to an OUT slot gets ACK (`rsp_code`=1) when free space is at least the maximum packet size, and NAK otherwise.
- R6: At high speed an OUT token (`tok_kind`=1) to a slot with free space of at least one maximum packet stores the payload. The reply is NYET (`rsp_code`=3) when the free space left after storing is below the maximum packet size, and ACK otherwise.
- R7: An OUT token that finds less than one maximum packet of free space gets NAK, and its payload is not counted.
- R8: At full speed (`link_hs` low or `force_fs` high) a PING gets no response, and an accepted OUT always gets ACK, never NYET.
- R9: A token to an endpoint number that no enabled slot carries, or whose direction does not match the slot, gets no response and changes no count.
- R10: Each response appears for exactly one cycle, in the cycle after the clock edge that samples the token, and never without a token.
- R11: Slot 0 answers endpoint number 0 for both IN and OUT tokens through one shared buffer.
- R12: A buffer count never exceeds its slot's capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_hs | input | 1 | Link negotiated high speed |
| force_fs | input | 1 | Force full-speed behaviour |
| slot_en | input | NEP | Slot enable (bit 0 ignored, slot 0 always on) |
| slot_epnum | input | NEP*EPNW | Endpoint number per slot |
| slot_is_in | input | NEP | Slot direction, 1 = IN |
| slot_maxpkt | input | NEP*MPW | Maximum packet size per slot |
| slot_cap | input | NEP*CW | Buffer capacity per slot, bytes |
| slot_short | input | NEP | Short-send enable per slot |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | 0 IN, 1 OUT, 2 PING, 3 ignored |
| tok_ep | input | EPNW | Token endpoint number |
| tok_len | input | MPW | OUT payload length, bytes |
| host_ack | input | 1 | Host acknowledged last DATA reply |
| cpu_wr_en | input | 1 | Add bytes to a slot buffer |
| cpu_wr_slot | input | SW | Slot for write credit |
| cpu_wr_len | input | CW | Bytes written |
| cpu_rd_en | input | 1 | Remove bytes from a slot buffer |
| cpu_rd_slot | input | SW | Slot for read credit |
| cpu_rd_len | input | CW | Bytes read |
| rsp_valid | output | 1 | Handshake/data response strobe |
| rsp_code | output | 2 | 0 DATA, 1 ACK, 2 NAK, 3 NYET |
| rsp_len | output | MPW | DATA length, bytes |

## Verification
On every cycle the assertions check that a response only follows a sampled token and that a token the lookup rejects is answered by silence. They also check that no NYET or PING reply escapes at full speed and that no buffer count passes its capacity. The exact handshake choice depends on byte counts built up across several transactions, so only the bench's scenarios can show it. Those scenarios cover filling an OUT buffer to the NYET point, a discarded NAKed payload, data kept after an IN reply the host never acknowledged, and short and zero-length sends.

// File: rtl/ep_resp_pkg.sv
package ep_resp_pkg;
  typedef enum logic [1:0] {
    TK_IN   = 2'd0,
    TK_OUT  = 2'd1,
    TK_PING = 2'd2,
    TK_RSVD = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    RS_DATA = 2'd0,
    RS_ACK  = 2'd1,
    RS_NAK  = 2'd2,
    RS_NYET = 2'd3
  } rsp_code_e;
endpackage

// File: rtl/ep_lookup.sv
module ep_lookup #(
  parameter int NEP  = 6,
  parameter int EPNW = 4,
  localparam int SW  = $clog2(NEP)
) (
  input  logic [NEP-1:0]      slot_en,
  input  logic [NEP*EPNW-1:0] slot_epnum,
  input  logic [NEP-1:0]      slot_is_in,
  input  logic [EPNW-1:0]     tok_ep,
  input  logic                want_in,
  input  logic                kind_ok,
  output logic                hit,
  output logic [SW-1:0]       slot
);
  logic [NEP-1:0] match;

  // slot 0 is the control endpoint: number 0, both directions
  assign match[0] = kind_ok && (tok_ep == '0);

  for (genvar i = 1; i < NEP; i++) begin : g_match
    assign match[i] = kind_ok && slot_en[i]
                      && (slot_epnum[i*EPNW +: EPNW] == tok_ep)
                      && (tok_ep != '0)
                      && (slot_is_in[i] == want_in);
  end

  always_comb begin
    hit  = 1'b0;
    slot = '0;
    for (int i = NEP - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit  = 1'b1;
        slot = SW'(i);
      end
    end
  end
endmodule

// File: rtl/ep_occ_ctr.sv
module ep_occ_ctr #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cap,
  input  logic          add_en,
  input  logic [CW:0]   add_amt,
  input  logic          sub_en,
  input  logic [CW:0]   sub_amt,
  output logic [CW-1:0] occ
);
  logic [CW:0]   sum;
  logic [CW:0]   capped;
  logic [CW-1:0] occ_nxt;
  logic          upd;

  always_comb begin
    sum    = {1'b0, occ} + (add_en ? add_amt : '0);
    capped = (sum > {1'b0, cap}) ? {1'b0, cap} : sum;
    if (sub_en && (sub_amt >= capped)) occ_nxt = '0;
    else if (sub_en)                   occ_nxt = CW'(capped - sub_amt);
    else                               occ_nxt = CW'(capped);
    upd = add_en || sub_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   occ <= '0;
    else if (upd) occ <= occ_nxt;
  end
endmodule

// File: rtl/ep_handshake_resp.sv
module ep_handshake_resp
  import ep_resp_pkg::*;
#(
  parameter int NEP  = 6,
  parameter int EPNW = 4,
  parameter int MPW  = 11,
  parameter int CW   = 13,
  localparam int SW  = $clog2(NEP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_hs,
  input  logic                force_fs,
  input  logic [NEP-1:0]      slot_en,
  input  logic [NEP*EPNW-1:0] slot_epnum,
  input  logic [NEP-1:0]      slot_is_in,
  input  logic [NEP*MPW-1:0]  slot_maxpkt,
  input  logic [NEP*CW-1:0]   slot_cap,
  input  logic [NEP-1:0]      slot_short,
  input  logic                tok_valid,
  input  logic [1:0]          tok_kind,
  input  logic [EPNW-1:0]     tok_ep,
  input  logic [MPW-1:0]      tok_len,
  input  logic                host_ack,
  input  logic                cpu_wr_en,
  input  logic [SW-1:0]       cpu_wr_slot,
  input  logic [CW-1:0]       cpu_wr_len,
  input  logic                cpu_rd_en,
  input  logic [SW-1:0]       cpu_rd_slot,
  input  logic [CW-1:0]       cpu_rd_len,
  output logic                rsp_valid,
  output logic [1:0]          rsp_code,
  output logic [MPW-1:0]      rsp_len
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  tok_kind_e kind;
  logic      hs_eff;
  logic      lk_hit;
  logic [SW-1:0] lk_slot;
  assign kind   = tok_kind_e'(tok_kind);
  assign hs_eff = link_hs && !force_fs;

  ep_lookup #(.NEP(NEP), .EPNW(EPNW)) u_lookup (
    .slot_en    (slot_en),
    .slot_epnum (slot_epnum),
    .slot_is_in (slot_is_in),
    .tok_ep     (tok_ep),
    .want_in    (kind == TK_IN),
    .kind_ok    (kind != TK_RSVD),
    .hit        (lk_hit),
    .slot       (lk_slot)
  );

  logic [NEP*CW-1:0] occ_flat;
  logic [CW-1:0] occ_sel, cap_sel, free_sel, mp_ext, len_st, left_sp;
  logic [MPW-1:0] mp_sel;
  assign occ_sel  = occ_flat[lk_slot*CW +: CW];
  assign cap_sel  = slot_cap[lk_slot*CW +: CW];
  assign mp_sel   = slot_maxpkt[lk_slot*MPW +: MPW];
  assign mp_ext   = CW'(mp_sel);
  assign free_sel = cap_sel - occ_sel;
  assign len_st   = CW'((tok_len > mp_sel) ? mp_sel : tok_len);
  assign left_sp  = free_sel - len_st;

  // pending IN reply awaiting host acknowledgement
  logic           pend_v, pend_v_nxt;
  logic [SW-1:0]  pend_slot, pend_slot_nxt;
  logic [MPW-1:0] pend_len, pend_len_nxt;

  logic           rv_nxt;
  rsp_code_e      rc_nxt;
  logic [MPW-1:0] rl_nxt;
  logic           store_en;

  always_comb begin
    rv_nxt        = 1'b0;
    rc_nxt        = RS_NAK;
    rl_nxt        = '0;
    store_en      = 1'b0;
    pend_v_nxt    = pend_v && !host_ack;
    pend_slot_nxt = pend_slot;
    pend_len_nxt  = pend_len;
    if (tok_valid) pend_v_nxt = 1'b0;
    if (tok_valid && lk_hit) begin
      unique case (kind)
        TK_IN: begin
          rv_nxt = 1'b1;
          if (occ_sel >= mp_ext) begin
            rc_nxt = RS_DATA;
            rl_nxt = mp_sel;
          end else if (slot_short[lk_slot]) begin
            rc_nxt = RS_DATA;
            rl_nxt = occ_sel[MPW-1:0];
          end
          if (rc_nxt == RS_DATA) begin
            pend_v_nxt    = 1'b1;
            pend_slot_nxt = lk_slot;
            pend_len_nxt  = rl_nxt;
          end
        end
        TK_PING: begin
          rv_nxt = hs_eff;
          rc_nxt = (free_sel >= mp_ext) ? RS_ACK : RS_NAK;
        end
        TK_OUT: begin
          rv_nxt = 1'b1;
          if (free_sel >= mp_ext) begin
            store_en = 1'b1;
            rc_nxt   = (hs_eff && (left_sp < mp_ext)) ? RS_NYET : RS_ACK;
          end
        end
        default: rv_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      rsp_len   <= '0;
      pend_v    <= 1'b0;
      pend_slot <= '0;
      pend_len  <= '0;
    end else begin
      rsp_valid <= rv_nxt;
      if (rv_nxt) begin
        rsp_code <= rc_nxt;
        rsp_len  <= rl_nxt;
      end
      pend_v <= pend_v_nxt;
      if (pend_v_nxt) begin
        pend_slot <= pend_slot_nxt;
        pend_len  <= pend_len_nxt;
      end
    end
  end

  logic ack_take;
  assign ack_take = host_ack && pend_v;

  for (genvar i = 0; i < NEP; i++) begin : g_slot
    logic        a_usb, a_cpu, s_usb, s_cpu;
    logic [CW:0] a_amt, s_amt;
    assign a_usb = store_en && (lk_slot == SW'(i));
    assign a_cpu = cpu_wr_en && (cpu_wr_slot == SW'(i));
    assign s_usb = ack_take && (pend_slot == SW'(i));
    assign s_cpu = cpu_rd_en && (cpu_rd_slot == SW'(i));
    assign a_amt = (a_usb ? {1'b0, len_st} : '0)
                 + (a_cpu ? {1'b0, cpu_wr_len} : '0);
    assign s_amt = (s_usb ? (CW+1)'(pend_len) : '0)
                 + (s_cpu ? {1'b0, cpu_rd_len} : '0);
    ep_occ_ctr #(.CW(CW)) u_occ (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .cap     (slot_cap[i*CW +: CW]),
      .add_en  (a_usb || a_cpu),
      .add_amt (a_amt),
      .sub_en  (s_usb || s_cpu),
      .sub_amt (s_amt),
      .occ     (occ_flat[i*CW +: CW])
    );
  end
endmodule

// File: rtl/ep_resp_chk.sv
module ep_resp_chk
  import ep_resp_pkg::*;
#(
  parameter int NEP  = 6,
  parameter int EPNW = 4,
  parameter int MPW  = 11,
  parameter int CW   = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_hs,
  input logic              force_fs,
  input logic              tok_valid,
  input logic [1:0]        tok_kind,
  input logic              lk_hit,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic [NEP*CW-1:0] occ_flat,
  input logic [NEP*CW-1:0] slot_cap
);
  // R10: a response only ever follows a sampled token
  a_r10_rsp_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(tok_valid));

  // R9: a token the lookup rejects is answered by silence
  a_r9_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !lk_hit) |=> !rsp_valid);

  // R8: no NYET unless high speed was in effect when the token was sampled
  a_r8_no_nyet_fs: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == RS_NYET) |-> $past(link_hs && !force_fs));

  // R8: PING at full speed gets no response
  a_r8_ping_fs_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_PING && !(link_hs && !force_fs)) |=> !rsp_valid);

  // R12: occupancy bounded by capacity
  for (genvar i = 0; i < NEP; i++) begin : g_cap
    a_r12_occ_in_cap: assert property (@(posedge clk) disable iff (!rst_n)
      occ_flat[i*CW +: CW] <= slot_cap[i*CW +: CW]);
  end
endmodule

bind ep_handshake_resp ep_resp_chk #(.NEP(NEP), .EPNW(EPNW), .MPW(MPW), .CW(CW)) u_chk (.*);

// File: tb/tb_ep_handshake_resp.sv
`timescale 1ns/1ps
module tb_ep_handshake_resp;
  localparam int NEP = 6, EPNW = 4, MPW = 11, CW = 13, SW = 3;
  localparam int C_DATA = 0, C_ACK = 1, C_NAK = 2, C_NYET = 3;
  localparam int K_IN = 0, K_OUT = 1, K_PING = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic link_hs, force_fs;
  logic [NEP-1:0]      slot_en, slot_is_in, slot_short;
  logic [NEP*EPNW-1:0] slot_epnum;
  logic [NEP*MPW-1:0]  slot_maxpkt;
  logic [NEP*CW-1:0]   slot_cap;
  logic tok_valid, host_ack, cpu_wr_en, cpu_rd_en;
  logic [1:0] tok_kind;
  logic [EPNW-1:0] tok_ep;
  logic [MPW-1:0] tok_len;
  logic [SW-1:0] cpu_wr_slot, cpu_rd_slot;
  logic [CW-1:0] cpu_wr_len, cpu_rd_len;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic [MPW-1:0] rsp_len;

  always #4 clk = ~clk;

  ep_handshake_resp dut (.*);

  typedef struct packed {
    logic           v;
    logic [1:0]     code;
    logic [MPW-1:0] len;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // monitor: compares each expected item against the response slot
  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (rsp_valid !== e.v || (e.v && (rsp_code !== e.code ||
          (e.code == C_DATA && rsp_len !== e.len)))) begin
        n_fail++;
        $display("FAIL %s: got v=%0b code=%0d len=%0d, expected v=%0b code=%0d len=%0d",
                 t, rsp_valid, rsp_code, rsp_len, e.v, e.code, e.len);
      end
    end else if (rst_n && rsp_valid === 1'b1) begin
      n_tests++;
      n_fail++;
      $display("FAIL R10: got unsolicited response code=%0d, expected none", rsp_code);
    end
  end

  task automatic tok(input int kind, input int ep, input int len,
                     input bit ev, input int ecode, input int elen, input string tag);
    exp_t e;
    @(negedge clk);
    tok_valid = 1'b1;
    tok_kind  = 2'(kind);
    tok_ep    = EPNW'(ep);
    tok_len   = MPW'(len);
    e.v = ev; e.code = 2'(ecode); e.len = MPW'(elen);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic cpu_wr(input int s, input int n);
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_wr_slot = SW'(s); cpu_wr_len = CW'(n);
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic cpu_rd(input int s, input int n);
    @(negedge clk);
    cpu_rd_en = 1'b1; cpu_rd_slot = SW'(s); cpu_rd_len = CW'(n);
    @(negedge clk);
    cpu_rd_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    host_ack = 1'b1;
    @(negedge clk);
    host_ack = 1'b0;
  endtask

  function automatic void cfg(input int s, input bit en, input int ep,
                              input bit is_in, input int mp, input int cap);
    slot_en[s] = en;
    slot_epnum[s*EPNW +: EPNW] = EPNW'(ep);
    slot_is_in[s] = is_in;
    slot_maxpkt[s*MPW +: MPW] = MPW'(mp);
    slot_cap[s*CW +: CW] = CW'(cap);
  endfunction

  initial begin
    #150000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; link_hs = 1'b1; force_fs = 1'b0;
    tok_valid = 0; tok_kind = 0; tok_ep = 0; tok_len = 0; host_ack = 0;
    cpu_wr_en = 0; cpu_rd_en = 0; cpu_wr_slot = 0; cpu_rd_slot = 0;
    cpu_wr_len = 0; cpu_rd_len = 0;
    slot_short = '0; slot_en = '0; slot_is_in = '0;
    slot_epnum = '0; slot_maxpkt = '0; slot_cap = '0;
    cfg(0, 1, 0, 0, 64, 128);
    cfg(1, 1, 1, 1, 64, 256);
    cfg(2, 1, 2, 0, 64, 192);
    cfg(3, 1, 3, 0, 512, 1024);
    cfg(4, 0, 4, 1, 64, 128);
    cfg(5, 1, 5, 1, 8, 16);
    slot_short[5] = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got rsp_valid=%0b, expected 0", rsp_valid);
    end

    tok(K_IN, 1, 0, 1, C_NAK, 0, "R1 empty IN buffer");
    tok(K_PING, 2, 0, 1, C_ACK, 0, "R1 empty OUT buffer ping");
    tok(K_IN, 5, 0, 1, C_DATA, 0, "R4 zero-length short send");

    cpu_wr(1, 100);
    tok(K_IN, 1, 0, 1, C_DATA, 64, "R2 full packet");
    tok(K_IN, 1, 0, 1, C_DATA, 64, "R3 unacked data retained");
    ack();
    tok(K_IN, 1, 0, 1, C_NAK, 0, "R4 below maxpkt no short");
    cpu_wr(1, 28);
    tok(K_IN, 1, 0, 1, C_DATA, 64, "R2 refilled packet");
    ack();
    tok(K_IN, 1, 0, 1, C_NAK, 0, "R2 drained after ack");
    cpu_wr(5, 5);
    tok(K_IN, 5, 0, 1, C_DATA, 5, "R4 short send len");

    tok(K_OUT, 2, 64, 1, C_ACK, 0, "R6 out room left");
    tok(K_OUT, 2, 64, 1, C_ACK, 0, "R6 out exactly maxpkt left");
    tok(K_OUT, 2, 64, 1, C_NYET, 0, "R6 out nyet");
    tok(K_PING, 2, 0, 1, C_NAK, 0, "R5 ping full");
    tok(K_OUT, 2, 64, 1, C_NAK, 0, "R7 out no room");
    cpu_rd(2, 64);
    tok(K_PING, 2, 0, 1, C_ACK, 0, "R7 nak payload discarded");
    tok(K_OUT, 2, 10, 1, C_NYET, 0, "R6 small out nyet");

    force_fs = 1'b1;
    tok(K_PING, 2, 0, 0, 0, 0, "R8 ping at full speed");
    tok(K_OUT, 2, 10, 1, C_NAK, 0, "R8 fs out no room");
    cpu_rd(2, 128);
    tok(K_OUT, 2, 64, 1, C_ACK, 0, "R8 fs out ack");
    tok(K_OUT, 2, 64, 1, C_ACK, 0, "R8 fs no nyet");
    force_fs = 1'b0;
    link_hs  = 1'b0;
    tok(K_PING, 2, 0, 0, 0, 0, "R8 ping fs link");
    link_hs  = 1'b1;
    tok(K_PING, 2, 0, 1, C_NAK, 0, "R8 hs ping after fs outs");

    tok(K_IN, 4, 0, 0, 0, 0, "R9 disabled slot");
    tok(K_OUT, 1, 8, 0, 0, 0, "R9 direction mismatch");
    tok(K_IN, 7, 0, 0, 0, 0, "R9 unknown endpoint");
    tok(K_IN, 1, 0, 1, C_NAK, 0, "R9 IN buffer untouched");
    tok(3, 1, 0, 0, 0, 0, "R9 reserved kind");

    tok(K_OUT, 0, 8, 1, C_ACK, 0, "R11 ep0 out");
    tok(K_IN, 0, 0, 1, C_NAK, 0, "R11 ep0 in below maxpkt");
    slot_short[0] = 1'b1;
    tok(K_IN, 0, 0, 1, C_DATA, 8, "R11 ep0 shared buffer");
    tok(K_PING, 3, 0, 1, C_ACK, 0, "R5 large maxpkt ping");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule